// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port with Interrupt Flags

This block is the host-facing register file of a real-time clock. A host reaches a 128-byte space through two addresses: the even address holds a 7-bit index, and the odd address reads or writes the byte that the index selects. Four of those bytes are control and status registers (A at 0x0A, B at 0x0B, C at 0x0C, D at 0x0D). The remainder is plain battery-style storage. Time keeping and alarm comparison live elsewhere. They deliver single-cycle pulses for "update started", "update done" and "alarm match", plus a base tick from which the block divides its own periodic interrupt.

The block keeps the interrupt flags in register C, combines them with the enables in register B, and drives a level interrupt output that follows the summary flag. The output falls when software reads register C, which clears the whole register. A functional reset input returns the interrupt state to a quiet condition. It also preserves a suspend marker held in the shutdown byte.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address loads the index from data bits 6:0, ignoring bit 7. A read of the even address returns 0xFF.
- R2: Odd-address accesses to indices other than 0x0A–0x0D write and read back an ordinary storage byte.
- R3: Writes to register C (0x0C) and register D (0x0D) change nothing. Register D always reads 0x80, where bit 7 means valid time and RAM.
- R4: Bit 7 of register A (update in progress) cannot be written, and a write to A keeps its value. An update-start pulse sets it and an update-done pulse clears it.
- R5: A read of register C returns its current flags. The register then becomes 0x00 and the interrupt output is low in the next cycle.
- R6: An update-done pulse sets C bit 4 and an alarm pulse sets C bit 5. If a newly set flag has its enable in B (bit 4 for update, bit 5 for alarm), C bit 7 (summary) and the interrupt output are set in the next cycle.
- R7: A flag set while its enable is off leaves the summary bit and the interrupt output low.
- R8: Writing B with an enable whose flag is already pending raises the summary bit and the interrupt in the next cycle. Any other write to B clears the summary bit and drops the interrupt.
- R9: Writing B with bit 7 (hold) set stores the update enable (bit 4) as 0. It also clears the update-in-progress bit, and update-start pulses are ignored while hold is set.
- R10: After reset, A=0x26, B=0x02, C=0x00, D=0x80, the index is 0 and the interrupt output is low.
- R11: A functional reset clears B bits 6 (periodic enable), 5 (alarm enable) and 3 (square-wave enable) and all of register C. It clears storage byte 0x0F unless that byte holds 0xFE.
- R12: When A bits 3:0 hold a nonzero code n, C bit 6 (periodic flag) is set once every 2^(n−1) base ticks. The count restarts whenever the code changes, and code 0 produces no periodic flag. If B bit 6 is set, each periodic flag also sets the summary bit.
- R13: An event pulse in the same cycle as a read of register C is not lost. The read returns the old flags, and the new flag, together with its summary bit when enabled, remains set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| func_rst | input | 1 | Functional reset pulse |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| base_tick | input | 1 | Base tick for the periodic divider |
| ev_uip_start | input | 1 | Update-start pulse |
| ev_update | input | 1 | Update-done pulse |
| ev_alarm | input | 1 | Alarm-match pulse |
| irq_o | output | 1 | Level interrupt output, mirrors the summary flag |

## Verification
A host read of register C and an event pulse can land in the same clock. The clear-on-read and the flag set then compete for register C. The bench provokes this by asserting the read strobe and an update-done pulse together, both with the flag register empty and with an unrelated alarm flag already pending. It judges the result by the byte returned in that cycle, which must be the old flags. It then checks the interrupt output on the next cycle and reads C again, which must show the new flag with its summary bit. A second overlap, a write to register B in the same cycle as an event, is covered by the ordering rule: events are applied after the host's change.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
    localparam int IDX_W  = 7;
    localparam int DATA_W = 8;
    localparam int RATE_W = 4;

    localparam logic [IDX_W-1:0] IDX_CTLA  = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_CTLB  = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_FLAGS = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_VALID = 7'h0D;
    localparam logic [IDX_W-1:0] IDX_SHUT  = 7'h0F;

    localparam int A_BUSY  = 7;
    localparam int B_HOLD  = 7;
    localparam int B_PIE   = 6;
    localparam int B_AIE   = 5;
    localparam int B_UIE   = 4;
    localparam int B_SQW   = 3;
    localparam int C_SUM   = 7;
    localparam int C_PER   = 6;
    localparam int C_ALM   = 5;
    localparam int C_UPD   = 4;

    localparam logic [DATA_W-1:0] RST_CTLA  = 8'h26;
    localparam logic [DATA_W-1:0] RST_CTLB  = 8'h02;
    localparam logic [DATA_W-1:0] RST_FLAGS = 8'h00;
    localparam logic [DATA_W-1:0] VALID_VAL = 8'h80;
    localparam logic [DATA_W-1:0] SHUT_KEEP = 8'hFE;
    localparam logic [DATA_W-1:0] IDX_READ  = 8'hFF;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] ctla;
        logic [DATA_W-1:0] ctlb;
        logic [DATA_W-1:0] flags;
    } port_state_t;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    input  logic              base_tick,
    output logic              tick_o
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = '0;
        if (code != '0) begin
            last_cnt = (CNT_W'(1) << (code - CODE_W'(1))) - CNT_W'(1);
        end
    end

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (restart || code == '0) begin
            cnt_d = '0;
        end else if (base_tick) begin
            if (cnt_q >= last_cnt) begin
                tick_o = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int                ADDR_W   = 7,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] KEEP_IDX = 7'h0F,
    parameter logic [DATA_W-1:0] KEEP_VAL = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[addr] = wdata;
        if (soft_clr && mem_q[KEEP_IDX] != KEEP_VAL) mem_d[KEEP_IDX] = '0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              func_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              base_tick,
    input  logic              ev_uip_start,
    input  logic              ev_update,
    input  logic              ev_alarm,
    output logic              irq_o
);
    port_state_t st_d, st_q;

    logic              rd_data, wr_data, wr_index;
    logic              per_tick, div_restart, store_we;
    logic              is_ctl;
    logic [DATA_W-1:0] store_rdata;
    logic [2:0]        ev_bits, fresh_bits;

    logic [IDX_W-1:0]  reg_idx;
    logic [DATA_W-1:0] reg_a, reg_b, reg_c;

    assign rd_data  = bus_sel && !bus_wr && bus_addr;
    assign wr_data  = bus_sel && bus_wr && bus_addr;
    assign wr_index = bus_sel && bus_wr && !bus_addr;
    assign is_ctl   = (st_q.idx >= IDX_CTLA) && (st_q.idx <= IDX_VALID);
    assign store_we = wr_data && !is_ctl;
    assign div_restart = wr_data && (st_q.idx == IDX_CTLA) &&
                         (bus_wdata[RATE_W-1:0] != st_q.ctla[RATE_W-1:0]);

    rtc_rate_div #(.CODE_W(RATE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (div_restart),
        .code      (st_q.ctla[RATE_W-1:0]),
        .base_tick (base_tick),
        .tick_o    (per_tick)
    );

    rtc_byte_store #(
        .ADDR_W   (IDX_W),
        .DATA_W   (DATA_W),
        .KEEP_IDX (IDX_SHUT),
        .KEEP_VAL (SHUT_KEEP)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (func_rst),
        .wr_en    (store_we),
        .addr     (st_q.idx),
        .wdata    (bus_wdata),
        .rdata    (store_rdata)
    );

    // Next-state: host access first, then events, functional reset last.
    always_comb begin
        st_d       = st_q;
        ev_bits    = '0;
        fresh_bits = '0;

        if (wr_index) st_d.idx = bus_wdata[IDX_W-1:0];

        if (rd_data && st_q.idx == IDX_FLAGS) st_d.flags = '0;

        if (wr_data) begin
            unique case (st_q.idx)
                IDX_CTLA: st_d.ctla = {st_q.ctla[A_BUSY], bus_wdata[A_BUSY-1:0]};
                IDX_CTLB: begin
                    st_d.ctlb = bus_wdata;
                    if (bus_wdata[B_HOLD]) begin
                        st_d.ctlb[B_UIE]  = 1'b0;
                        st_d.ctla[A_BUSY] = 1'b0;
                    end
                    st_d.flags[C_SUM] = |(st_d.ctlb[B_PIE:B_UIE] & st_q.flags[C_PER:C_UPD]);
                end
                default: ;
            endcase
        end

        if (ev_uip_start && !st_d.ctlb[B_HOLD]) st_d.ctla[A_BUSY] = 1'b1;
        if (ev_update)                          st_d.ctla[A_BUSY] = 1'b0;

        ev_bits    = {per_tick, ev_alarm, ev_update};
        fresh_bits = ev_bits & ~st_d.flags[C_PER:C_UPD];
        st_d.flags[C_PER:C_UPD] = st_d.flags[C_PER:C_UPD] | ev_bits;
        if (|(fresh_bits & st_d.ctlb[B_PIE:B_UIE])) st_d.flags[C_SUM] = 1'b1;
        if (per_tick && st_d.ctlb[B_PIE])            st_d.flags[C_SUM] = 1'b1;

        if (func_rst) begin
            st_d.ctlb[B_PIE] = 1'b0;
            st_d.ctlb[B_AIE] = 1'b0;
            st_d.ctlb[B_SQW] = 1'b0;
            st_d.flags       = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx   <= '0;
            st_q.ctla  <= RST_CTLA;
            st_q.ctlb  <= RST_CTLB;
            st_q.flags <= RST_FLAGS;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!bus_addr) begin
            bus_rdata = IDX_READ;
        end else begin
            unique case (st_q.idx)
                IDX_CTLA:  bus_rdata = st_q.ctla;
                IDX_CTLB:  bus_rdata = st_q.ctlb;
                IDX_FLAGS: bus_rdata = st_q.flags;
                IDX_VALID: bus_rdata = VALID_VAL;
                default:   bus_rdata = store_rdata;
            endcase
        end
    end

    assign irq_o   = st_q.flags[C_SUM];
    assign reg_idx = st_q.idx;
    assign reg_a   = st_q.ctla;
    assign reg_b   = st_q.ctlb;
    assign reg_c   = st_q.flags;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       func_rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       ev_uip_start,
    input logic       ev_update,
    input logic       ev_alarm,
    input logic       per_tick,
    input logic       irq_o,
    input logic [6:0] reg_idx,
    input logic [7:0] reg_a,
    input logic [7:0] reg_b,
    input logic [7:0] reg_c
);
    logic wr_odd, rd_odd;
    assign wr_odd = bus_sel && bus_wr && bus_addr;
    assign rd_odd = bus_sel && !bus_wr && bus_addr;

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_odd && reg_idx == 7'h0C && !ev_update && !ev_alarm && !per_tick)
        |=> (!irq_o && reg_c == 8'h00));

    assert_flags_unwritable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && reg_idx == 7'h0C && !ev_update && !ev_alarm && !per_tick && !func_rst)
        |=> (reg_c == $past(reg_c)));

    assert_busy_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && reg_idx == 7'h0A && !ev_uip_start && !ev_update)
        |=> (reg_a[7] == $past(reg_a[7])));

    assert_hold_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && reg_idx == 7'h0B && bus_wdata[7])
        |=> (!reg_b[4] && !reg_a[7]));

    assert_update_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_update && reg_b[4] && !func_rst && !(wr_odd && reg_idx == 7'h0B))
        |=> irq_o);

    assert_func_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        func_rst |=> (reg_c == 8'h00 && (reg_b & 8'h68) == 8'h00 && !irq_o));

    assert_periodic_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (per_tick && !func_rst) |=> reg_c[6]);
endmodule

bind rtc_regport rtc_regport_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .func_rst     (func_rst),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .ev_uip_start (ev_uip_start),
    .ev_update    (ev_update),
    .ev_alarm     (ev_alarm),
    .per_tick     (per_tick),
    .irq_o        (irq_o),
    .reg_idx      (reg_idx),
    .reg_a        (reg_a),
    .reg_b        (reg_b),
    .reg_c        (reg_c)
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       func_rst = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       base_tick = 1'b0;
    logic       ev_uip_start = 1'b0;
    logic       ev_update = 1'b0;
    logic       ev_alarm = 1'b0;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    rtc_regport u_dut (
        .clk(clk), .rst_n(rst_n), .func_rst(func_rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .base_tick(base_tick), .ev_uip_start(ev_uip_start),
        .ev_update(ev_update), .ev_alarm(ev_alarm), .irq_o(irq_o)
    );

    // Monitor: every host read pops one expected byte from the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (bus_sel && !bus_wr) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bus_rdata !== e) begin
                        errors++;
                        $display("FAIL %s read: actual %02h expected %02h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    task automatic host(input logic wr, input logic adr, input logic [7:0] d,
                        input logic upd, input logic alm);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = adr; bus_wdata = d;
        ev_update = upd; ev_alarm = alm;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; ev_update = 1'b0; ev_alarm = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        host(1'b1, 1'b0, idx, 1'b0, 1'b0);
        host(1'b1, 1'b1, d, 1'b0, 1'b0);
    endtask

    task automatic rd_reg(input logic [7:0] idx, input logic [7:0] e, input string t);
        host(1'b1, 1'b0, idx, 1'b0, 1'b0);
        exp_q.push_back(e); tag_q.push_back(t);
        host(1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    endtask

    // Read register C with an update-done pulse in the same cycle.
    task automatic rd_flags_with_update(input logic [7:0] e, input string t);
        host(1'b1, 1'b0, 8'h0C, 1'b0, 1'b0);
        exp_q.push_back(e); tag_q.push_back(t);
        host(1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_uip_start = 1'b1;
            1: ev_update = 1'b1;
            2: ev_alarm = 1'b1;
            3: base_tick = 1'b1;
            default: func_rst = 1'b1;
        endcase
        @(posedge clk);
        #1;
        ev_uip_start = 1'b0; ev_update = 1'b0; ev_alarm = 1'b0;
        base_tick = 1'b0; func_rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) pulse(3);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        #2;
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq: actual %0b expected %0b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk_irq(1'b0, "R10");
        rd_reg(8'h0A, 8'h26, "R10");
        rd_reg(8'h0B, 8'h02, "R10");
        rd_reg(8'h0C, 8'h00, "R10");
        rd_reg(8'h0D, 8'h80, "R10");

        // R1 index port
        exp_q.push_back(8'hFF); tag_q.push_back("R1");
        host(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        wr_reg(8'h85, 8'h5A);
        rd_reg(8'h05, 8'h5A, "R1");

        // R2 storage bytes
        wr_reg(8'h40, 8'h33);
        wr_reg(8'h7F, 8'hC4);
        rd_reg(8'h40, 8'h33, "R2");
        rd_reg(8'h7F, 8'hC4, "R2");

        // R3 flags and valid registers unwritable
        wr_reg(8'h0C, 8'hFF);
        wr_reg(8'h0D, 8'h00);
        rd_reg(8'h0C, 8'h00, "R3");
        rd_reg(8'h0D, 8'h80, "R3");
        chk_irq(1'b0, "R3");

        // R4 busy bit
        pulse(0);
        rd_reg(8'h0A, 8'hA6, "R4");
        wr_reg(8'h0A, 8'h05);
        rd_reg(8'h0A, 8'h85, "R4");
        pulse(1);
        rd_reg(8'h0A, 8'h05, "R4");
        rd_reg(8'h0C, 8'h10, "R6");
        rd_reg(8'h0C, 8'h00, "R5");
        wr_reg(8'h0A, 8'h26);

        // R9 hold bit
        pulse(0);
        wr_reg(8'h0B, 8'h92);
        rd_reg(8'h0B, 8'h82, "R9");
        rd_reg(8'h0A, 8'h26, "R9");
        pulse(0);
        rd_reg(8'h0A, 8'h26, "R9");
        wr_reg(8'h0B, 8'h02);

        // R7 / R8 / R5 alarm flag and enable ordering
        pulse(2);
        chk_irq(1'b0, "R7");
        wr_reg(8'h0B, 8'h22);
        chk_irq(1'b1, "R8");
        rd_reg(8'h0C, 8'hA0, "R5");
        chk_irq(1'b0, "R5");
        wr_reg(8'h0B, 8'h22);
        chk_irq(1'b0, "R8");
        pulse(2);
        chk_irq(1'b1, "R6");
        wr_reg(8'h0B, 8'h02);
        chk_irq(1'b0, "R8");
        rd_reg(8'h0C, 8'h20, "R8");

        // R6 update interrupt
        wr_reg(8'h0B, 8'h12);
        pulse(1);
        chk_irq(1'b1, "R6");
        rd_reg(8'h0C, 8'h90, "R6");
        chk_irq(1'b0, "R5");

        // R13 read of C colliding with an event
        rd_flags_with_update(8'h00, "R13");
        chk_irq(1'b1, "R13");
        rd_reg(8'h0C, 8'h90, "R13");
        pulse(2);
        rd_flags_with_update(8'h20, "R13");
        chk_irq(1'b1, "R13");
        rd_reg(8'h0C, 8'h90, "R13");

        // R12 periodic divider
        wr_reg(8'h0B, 8'h02);
        wr_reg(8'h0A, 8'h23);
        ticks(3);
        rd_reg(8'h0C, 8'h00, "R12");
        ticks(1);
        rd_reg(8'h0C, 8'h40, "R12");
        chk_irq(1'b0, "R12");
        wr_reg(8'h0B, 8'h42);
        ticks(4);
        chk_irq(1'b1, "R12");
        rd_reg(8'h0C, 8'hC0, "R12");
        wr_reg(8'h0A, 8'h21);
        ticks(1);
        rd_reg(8'h0C, 8'hC0, "R12");
        wr_reg(8'h0A, 8'h20);
        ticks(10);
        rd_reg(8'h0C, 8'h00, "R12");

        // R11 functional reset
        wr_reg(8'h0B, 8'h6A);
        pulse(1);
        wr_reg(8'h0F, 8'hFE);
        pulse(4);
        rd_reg(8'h0B, 8'h02, "R11");
        rd_reg(8'h0C, 8'h00, "R11");
        rd_reg(8'h0F, 8'hFE, "R11");
        wr_reg(8'h0F, 8'h12);
        pulse(4);
        rd_reg(8'h0F, 8'h00, "R11");
        chk_irq(1'b0, "R11");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule